// File: doc/BRIEF.md
# Duty-Cycle Pulse Tone Generator

This block produces a rectangular tone for a sound subsystem. Software programs an 11-bit period value with two byte-wide writes. A down-counting timer, advanced by an external tick, sets the pitch. Each time the timer runs out, an 8-position sequencer reads one bit from the selected duty pattern. That bit decides whether the output amplitude becomes the current volume or zero.

The volume, the duty selection and the channel shut-off come from outside. An envelope unit, a length counter and a sweep unit can drive them without any change to the tone core. The high-byte write also carries a trigger bit and a length-enable bit. Both are kept as flags and brought out as ports for those neighbouring units.

Top module: `pulse_tone_gen`

## Requirements
- R1: After reset `amp`, `active` and `len_en` are 0, and the internal timer and sequence position are 0. The first `tick` after reset therefore expires the timer at once.
- R2: A `wr_lo` write loads `wr_data[7:0]` into period bits 7:0. A `wr_hi` write loads `wr_data[2:0]` into period bits 10:8. Each write leaves the other period bits unchanged.
- R3: The timer changes only on a cycle with `tick` high. On such a cycle it decrements and saturates at 0. Without `tick`, `amp` keeps its value.
- R4: When a decrement leaves the timer at 0, that tick is an expiry and the timer reloads with (2048 − period) × 4. The interval between expiries is therefore (2048 − period) × 4 ticks, so period 0 gives 8192 ticks.
- R5: The sequence position is 3 bits and steps by one on every expiry, wrapping from 7 to 0. The output sample at an expiry uses the position before the step.
- R6: `duty_sel` picks a pattern. Read left to right as positions 0..7, the patterns are: 0 = 00000001, 1 = 10000001, 2 = 10000111, 3 = 01111110. At an expiry on an active channel, `amp` becomes `volume` when the pattern bit is 1 and 0 otherwise.
- R7: On a channel that is not active, every expiry sets `amp` to 0. The position still steps.
- R8: A `wr_hi` write with bit 7 set makes `active` 1. A `wr_hi` write with bit 7 clear leaves `active` unchanged. `chan_off` clears `active`, but a trigger in the same cycle takes priority.
- R9: A `wr_hi` write with bit 6 set makes `len_en` 1. Writes with bit 6 clear leave it unchanged, and only reset clears it.
- R10: `volume` and `duty_sel` are sampled only at an expiry. Changing them between expiries has no effect on `amp` until the next expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer advance strobe |
| wr_lo | input | 1 | Write strobe for period low byte |
| wr_hi | input | 1 | Write strobe for period high bits and control flags |
| wr_data | input | 8 | Write data byte |
| duty_sel | input | 2 | Duty pattern select |
| volume | input | 4 | Amplitude used for a high pattern bit |
| chan_off | input | 1 | Clears the channel-active flag |
| amp | output | 4 | Tone amplitude |
| len_en | output | 1 | Length-enable flag |
| active | output | 1 | Channel-active flag |

## Verification
A wrong timer count or reload value shows at `amp` as an edge that arrives early or late. The error becomes visible at the first expiry after the fault, which is at most (2048 − period) × 4 ticks later. A wrong sequence position, or a step taken before the sample, shows as a high or low level landing on the wrong step of the pattern within one pattern cycle of eight expiries. A stuck or leaking active flag appears both on the `active` port and as a missing or spurious nonzero `amp` at the next expiry. The scoreboard compares `amp` on every ticked cycle, so each of these faults is reported at the first cycle where it changes the output.

// File: rtl/pulse_tone_pkg.sv
`timescale 1ns/1ps
package pulse_tone_pkg;

    localparam int STEP_W  = 3;
    localparam int PAT_W   = 1 << STEP_W;
    localparam int SEL_W   = 2;
    localparam int NUM_PAT = 1 << SEL_W;

    // Position 0 is the most significant bit of each pattern.
    function automatic logic [PAT_W-1:0] duty_pattern(input logic [SEL_W-1:0] sel);
        logic [PAT_W-1:0] p;
        case (sel)
            2'd0:    p = 8'b0000_0001;
            2'd1:    p = 8'b1000_0001;
            2'd2:    p = 8'b1000_0111;
            default: p = 8'b0111_1110;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pulse_tone_regs.sv
`timescale 1ns/1ps
module pulse_tone_regs #(
    parameter int PERIOD_W = 11,
    parameter int BYTE_W   = 8,
    parameter int LEN_BIT  = 6,
    parameter int TRIG_BIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                chan_off,
    output logic [PERIOD_W-1:0] period,
    output logic                len_en,
    output logic                active
);
    localparam int HI_W = PERIOD_W - BYTE_W;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic                len_en;
        logic                active;
    } regs_t;

    regs_t st_d, st_q;
    logic  data_unused;

    assign data_unused = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.period[BYTE_W-1:0] = wr_data;
        end
        if (wr_hi) begin
            st_d.period[PERIOD_W-1:BYTE_W] = wr_data[HI_W-1:0];
            if (wr_data[LEN_BIT]) begin
                st_d.len_en = 1'b1;
            end
        end
        if (chan_off) begin
            st_d.active = 1'b0;
        end
        // Trigger takes priority over a same-cycle shut-off.
        if (wr_hi && wr_data[TRIG_BIT]) begin
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period = st_q.period;
    assign len_en = st_q.len_en;
    assign active = st_q.active;
endmodule

// File: rtl/pulse_tone_timer.sv
`timescale 1ns/1ps
module pulse_tone_timer #(
    parameter int PERIOD_W = 11,
    parameter int SHIFT    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    localparam int TIMER_W = PERIOD_W + SHIFT + 1;
    localparam logic [PERIOD_W:0] SPAN_TOP = (PERIOD_W+1)'(1) << PERIOD_W;

    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
    } tmr_t;

    tmr_t               tm_d, tm_q;
    logic [PERIOD_W:0]  span;
    logic [TIMER_W-1:0] reload;
    logic [TIMER_W-1:0] dec;

    always_comb begin
        span   = SPAN_TOP - {1'b0, period};
        reload = TIMER_W'(span) << SHIFT;
        dec    = (tm_q.cnt == '0) ? '0 : (tm_q.cnt - TIMER_W'(1));
        expire = tick && (dec == '0);
        tm_d   = tm_q;
        if (tick) begin
            tm_d.cnt = expire ? reload : dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end
endmodule

// File: rtl/pulse_tone_seq.sv
`timescale 1ns/1ps
module pulse_tone_seq
    import pulse_tone_pkg::*;
#(
    parameter int AMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             active,
    input  logic [SEL_W-1:0] duty_sel,
    input  logic [AMP_W-1:0] volume,
    output logic [AMP_W-1:0] amp
);
    localparam logic [STEP_W-1:0] LAST_POS = STEP_W'(PAT_W - 1);

    typedef struct packed {
        logic [STEP_W-1:0] pos;
        logic [AMP_W-1:0]  amp;
    } seq_t;

    seq_t              sq_d, sq_q;
    logic [PAT_W-1:0]  pat_tbl [NUM_PAT];
    logic [PAT_W-1:0]  cur_pat;
    logic [STEP_W-1:0] bit_idx;
    logic              duty_bit;

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        assign pat_tbl[g] = duty_pattern(SEL_W'(g));
    end

    always_comb begin
        cur_pat  = pat_tbl[duty_sel];
        bit_idx  = LAST_POS - sq_q.pos;
        duty_bit = cur_pat[bit_idx];
        sq_d     = sq_q;
        if (expire) begin
            sq_d.amp = (active && duty_bit) ? volume : '0;
            sq_d.pos = sq_q.pos + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign amp = sq_q.amp;
endmodule

// File: rtl/pulse_tone_gen.sv
`timescale 1ns/1ps
module pulse_tone_gen
    import pulse_tone_pkg::*;
#(
    parameter int PERIOD_W = 11,
    parameter int BYTE_W   = 8,
    parameter int AMP_W    = 4,
    parameter int SHIFT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  duty_sel,
    input  logic [AMP_W-1:0]  volume,
    input  logic              chan_off,
    output logic [AMP_W-1:0]  amp,
    output logic              len_en,
    output logic              active
);
    logic [PERIOD_W-1:0] period;
    logic                expire;

    pulse_tone_regs #(
        .PERIOD_W(PERIOD_W),
        .BYTE_W  (BYTE_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .chan_off(chan_off),
        .period  (period),
        .len_en  (len_en),
        .active  (active)
    );

    pulse_tone_timer #(
        .PERIOD_W(PERIOD_W),
        .SHIFT   (SHIFT)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .period(period),
        .expire(expire)
    );

    pulse_tone_seq #(
        .AMP_W(AMP_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .active  (active),
        .duty_sel(duty_sel),
        .volume  (volume),
        .amp     (amp)
    );
endmodule

// File: rtl/pulse_tone_gen_chk.sv
`timescale 1ns/1ps
module pulse_tone_gen_chk #(
    parameter int AMP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             trig_wr,
    input logic             chan_off,
    input logic [AMP_W-1:0] volume,
    input logic [AMP_W-1:0] amp,
    input logic             len_en,
    input logic             active
);
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(amp)); // R3

    AST_AMP_FROM_VOLUME: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ($stable(amp) || amp == '0 || amp == $past(volume))); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(amp) || amp == '0)); // R7

    AST_TRIGGER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> active); // R8

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_off && !trig_wr) |=> !active); // R8

    AST_LEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        len_en |=> len_en); // R9
endmodule

bind pulse_tone_gen pulse_tone_gen_chk #(.AMP_W(AMP_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .trig_wr (wr_hi & wr_data[7]),
    .chan_off(chan_off),
    .volume  (volume),
    .amp     (amp),
    .len_en  (len_en),
    .active  (active)
);

// File: tb/pulse_tone_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_tone_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] duty_sel = '0;
    logic [3:0] volume = '0;
    logic       chan_off = 1'b0;
    logic [3:0] amp;
    logic       len_en;
    logic       active;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_tone_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .duty_sel(duty_sel), .volume(volume),
        .chan_off(chan_off), .amp(amp), .len_en(len_en), .active(active)
    );

    // Reference model state, built from the requirements.
    int m_timer = 0;
    int m_pos = 0;
    int m_period = 0;
    bit m_active = 0;
    bit m_len = 0;
    int m_amp = 0;

    int    exp_q[$];
    string tag_q[$];

    function automatic bit pat_bit(input int sel, input int pos);
        logic [7:0] p;
        case (sel)
            0: p = 8'b00000001;
            1: p = 8'b10000001;
            2: p = 8'b10000111;
            default: p = 8'b01111110;
        endcase
        return p[7 - pos];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: ticks the design and pushes the expected amplitude.
    task automatic tick_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            m_timer = (m_timer > 0) ? m_timer - 1 : 0;
            if (m_timer == 0) begin
                m_amp = (m_active && pat_bit(int'(duty_sel), m_pos)) ? int'(volume) : 0;
                m_timer = (2048 - m_period) * 4;
                m_pos = (m_pos + 1) % 8;
            end
            exp_q.push_back(m_amp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic write_lo(input logic [7:0] v);
        @(negedge clk);
        wr_lo = 1'b1; wr_data = v;
        m_period = (m_period & 32'h700) | int'(v);
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic write_hi(input logic [7:0] v, input bit off_too);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = v; chan_off = off_too;
        m_period = (m_period & 32'h0FF) | (int'(v[2:0]) << 8);
        if (v[6]) m_len = 1;
        if (off_too) m_active = 0;
        if (v[7]) m_active = 1;
        @(negedge clk);
        wr_hi = 1'b0; chan_off = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk);
        chan_off = 1'b1; m_active = 0;
        @(negedge clk);
        chan_off = 1'b0;
    endtask

    // Monitor: compares each ticked cycle against the scoreboard queue.
    initial begin
        forever begin
            bit t;
            @(posedge clk);
            t = tick;
            #2;
            if (t) begin
                if (exp_q.size() == 0) begin
                    chk("R4 scoreboard underflow", 1, 0);
                end else begin
                    int e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(tg, int'(amp), e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 amp", int'(amp), 0);
        chk("R1 active", int'(active), 0);
        chk("R1 len_en", int'(len_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: period 2047 via both writes, no trigger, no length flag
        write_lo(8'hFF);
        write_hi(8'h07, 1'b0);
        chk("R8 no trigger", int'(active), 0);
        chk("R9 no len", int'(len_en), 0);
        // R1: first tick expires immediately on a disabled channel
        tick_n(1, "R1 first tick");
        tick_n(8, "R7 disabled steps");

        // R8: trigger
        write_hi(8'h87, 1'b0);
        chk("R8 trigger", int'(active), 1);
        volume = 4'hA;
        for (int s = 0; s < 4; s++) begin
            duty_sel = 2'(s);
            tick_n(32, "R6 pattern sweep / R5 order");
        end

        // R10: volume and duty changed mid-interval
        duty_sel = 2'd3; volume = 4'h5;
        tick_n(2, "R10 mid");
        volume = 4'hF;
        tick_n(3, "R10 mid");
        duty_sel = 2'd1;
        tick_n(1, "R10 mid");
        volume = 4'h3; duty_sel = 2'd2;
        tick_n(20, "R10 after change");

        // R3: hold without tick, period write does not disturb amp
        held = m_amp;
        write_lo(8'hFE);
        repeat (10) @(negedge clk);
        chk("R3 hold", int'(amp), held);
        tick_n(48, "R2 period 2046");

        // R7: shut-off forces zero at expiries
        pulse_off();
        chk("R8 off", int'(active), 0);
        duty_sel = 2'd3;
        tick_n(40, "R7 off zero");

        // R8: bit 7 clear leaves inactive; trigger wins over off
        write_hi(8'h07, 1'b0);
        chk("R8 no retrigger", int'(active), 0);
        write_hi(8'h87, 1'b1);
        chk("R8 trigger priority", int'(active), 1);

        // R9: sticky length enable
        write_hi(8'h47, 1'b0);
        chk("R9 len set", int'(len_en), 1);
        chk("R8 active kept", int'(active), 1);
        write_hi(8'h07, 1'b0);
        chk("R9 len sticky", int'(len_en), 1);

        // R2: low byte 0xF0 -> 2032, reload 64
        write_lo(8'hF0);
        volume = 4'h9; duty_sel = 2'd3;
        tick_n(600, "R2 low byte");
        // R2: high bits 6 -> 0x6F0, reload 1088
        write_hi(8'h06, 1'b0);
        tick_n(2400, "R2 high bits");

        // R4: period 0, reload 8192
        write_lo(8'h00);
        write_hi(8'h00, 1'b0);
        volume = 4'h7;
        tick_n(8192 * 3 + 5, "R4 period zero");

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule